// File: doc/BRIEF.md
# Intra Block Pixel Predictor

This block produces the predicted pixels of one square block from neighbour pixels that have already been reconstructed. A requester presents a prediction mode, a block size, the row of pixels above the block, the column to its left, the single pixel diagonally above-left, and two flags that say whether the upper and left edges hold real data. The block captures all of this in one handshake. It then streams the prediction out, one full row per beat, on a valid/ready output channel.

Four modes are provided: horizontal, vertical, DC and gradient. Horizontal copies each left pixel across its row. Vertical repeats the upper row on every row. DC fills the block with one rounded average. Gradient forms left plus above minus corner for each pixel and saturates the result into 0..255. The output bus is always sixteen pixels wide. Smaller blocks use the low lanes and drive the remaining lanes to zero.

Top module: `intra_pred_top`

## Requirements
- R1: `reqSize` selects the block dimension N: 0 gives 4, 1 gives 8, 2 (and the reserved 3) give 16. An accepted request yields exactly N output beats with `rowIndex` 0, 1, ..., N-1. `rowLast` is high only on the beat with index N-1.
- R2: Mode 0 (horizontal): every pixel of output row i equals left pixel i.
- R3: Mode 1 (vertical): every output row equals the first N upper pixels, lane j carrying upper pixel j.
- R4: Mode 2 (DC) with both edges available: every pixel equals (sum of N upper + sum of N left + N) >> log2(2N).
- R5: Mode 2 with exactly one edge available: every pixel equals (sum of that edge's N pixels + N/2) >> log2(N).
- R6: Mode 2 with neither edge available: every pixel equals 128.
- R7: Mode 3 (gradient): pixel (i,j) equals left[i] + upper[j] - corner, computed signed and saturated to 0..255.
- R8: Output lanes N..15 carry zero for blocks smaller than 16. Lane j occupies `rowData[8j+7:8j]`, and upper/left pixel k occupies bits [8k+7:8k] of its input.
- R9: While `rowValid` is high and `rowReady` is low, `rowData`, `rowIndex` and `rowLast` hold unchanged and `rowValid` stays high.
- R10: `reqReady` is high exactly when no block is being emitted. It is high after reset and in the cycle after the last row is taken. It is never high together with `rowValid`.
- R11: Mode, size, pixels and flags are captured when the request is accepted. Changing the inputs while a block is streaming has no effect on that block.
- R12: The availability flags have no effect in modes 0, 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken |
| reqMode | input | 2 | 0 horizontal, 1 vertical, 2 DC, 3 gradient |
| reqSize | input | 2 | 0: 4x4, 1: 8x8, 2/3: 16x16 |
| aboveAvail | input | 1 | Upper edge holds real data |
| leftAvail | input | 1 | Left edge holds real data |
| abovePix | input | 128 | Upper neighbour row, pixel k at bits [8k+7:8k] |
| leftPix | input | 128 | Left neighbour column, pixel k at bits [8k+7:8k] |
| cornerPix | input | 8 | Above-left neighbour pixel |
| rowValid | output | 1 | Output row present |
| rowReady | input | 1 | Consumer takes the row |
| rowData | output | 128 | Predicted row, lane j at bits [8j+7:8j] |
| rowIndex | output | 4 | Row number within the block |
| rowLast | output | 1 | Final row of the block |

## Verification
Some properties are checked on every cycle. These cover the handshake: rows are frozen under backpressure, the row index starts at zero and steps by one, the request side stays closed while rows stream, and it reopens right after the final beat. They also check the shape of the row: horizontal and DC rows are uniform across the active lanes, and vertical rows do not change from beat to beat. The arithmetic values are shown only by the bench scenarios. These are the rounding of each DC case, the saturation of the gradient at both ends, the zeroing of the unused lanes, and the fact that changed inputs and flags do not reach a block already in progress. The bench sweeps every mode, size and flag combination against sums it forms itself.

// File: rtl/intra_pred_pkg.sv
package intra_pred_pkg;

  localparam int MAX_DIM = 16;
  localparam int ROW_W   = $clog2(MAX_DIM);

  typedef enum logic [1:0] {
    MODE_HORZ = 2'd0,
    MODE_VERT = 2'd1,
    MODE_DC   = 2'd2,
    MODE_GRAD = 2'd3
  } predMode_t;

  typedef struct packed {
    logic             load;
    logic             advance;
    logic             busy;
    logic [ROW_W-1:0] rowIdx;
  } ctrlStrobes_t;

  function automatic logic [2:0] sizeToLog2(input logic [1:0] sizeCode);
    case (sizeCode)
      2'd0:    sizeToLog2 = 3'd2;
      2'd1:    sizeToLog2 = 3'd3;
      default: sizeToLog2 = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/intra_pred_ctrl.sv
module intra_pred_ctrl
  import intra_pred_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqSize,
  output logic             rowValid,
  input  logic             rowReady,
  output logic             rowLast,
  output logic [ROW_W-1:0] rowIndex,
  output ctrlStrobes_t     strobes
);

  typedef enum logic {ST_IDLE, ST_EMIT} ctrlState_t;

  ctrlState_t       stateQ;
  logic [ROW_W-1:0] rowCntQ;
  logic [ROW_W-1:0] lastRowQ;
  logic             accept;
  logic             advance;
  logic             atLast;
  logic [2:0]       reqLog2;

  assign reqLog2  = sizeToLog2(reqSize);
  assign reqReady = (stateQ == ST_IDLE);
  assign rowValid = (stateQ == ST_EMIT);
  assign accept   = reqReady && reqValid;
  assign advance  = rowValid && rowReady;
  assign atLast   = (rowCntQ == lastRowQ);
  assign rowLast  = rowValid && atLast;
  assign rowIndex = rowCntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      rowCntQ  <= '0;
      lastRowQ <= '0;
    end else if (accept) begin
      stateQ   <= ST_EMIT;
      rowCntQ  <= '0;
      lastRowQ <= ROW_W'((1 << reqLog2) - 1);
    end else if (advance) begin
      if (atLast) begin
        stateQ <= ST_IDLE;
      end else begin
        rowCntQ <= rowCntQ + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.load    = accept;
    strobes.advance = advance;
    strobes.busy    = rowValid;
    strobes.rowIdx  = rowCntQ;
  end

  assert_hold_row_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rowValid && !rowReady) |=> (rowValid && $stable(rowIndex) && $stable(rowLast)));

  assert_reopen_after_last_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rowValid && rowReady && rowLast) |=> reqReady);

  assert_closed_while_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    rowValid |-> !reqReady);

  assert_start_row_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (rowValid && rowIndex == '0));

  assert_row_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rowValid && rowReady && !rowLast) |=> (rowValid && rowIndex == $past(rowIndex) + 1'b1));

endmodule

// File: rtl/intra_pred_dc.sv
module intra_pred_dc
  import intra_pred_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic [MAX_DIM*PIX_W-1:0] aboveFlat,
  input  logic [MAX_DIM*PIX_W-1:0] leftFlat,
  input  logic [2:0]               log2Dim,
  input  logic                     availAbove,
  input  logic                     availLeft,
  output logic [PIX_W-1:0]         dcVal
);

  localparam int SUM_W = PIX_W + $clog2(MAX_DIM) + 2;

  logic [SUM_W-1:0] sumAbove;
  logic [SUM_W-1:0] sumLeft;
  logic [SUM_W-1:0] dimVal;
  logic [SUM_W-1:0] avgVal;

  always_comb begin
    dimVal   = SUM_W'(1) << log2Dim;
    sumAbove = '0;
    sumLeft  = '0;
    for (int k = 0; k < MAX_DIM; k++) begin
      if (SUM_W'(k) < dimVal) begin
        sumAbove = sumAbove + SUM_W'(aboveFlat[k*PIX_W +: PIX_W]);
        sumLeft  = sumLeft  + SUM_W'(leftFlat[k*PIX_W +: PIX_W]);
      end
    end
    case ({availAbove, availLeft})
      2'b11:   avgVal = (sumAbove + sumLeft + dimVal) >> (log2Dim + 3'd1);
      2'b10:   avgVal = (sumAbove + (dimVal >> 1)) >> log2Dim;
      2'b01:   avgVal = (sumLeft + (dimVal >> 1)) >> log2Dim;
      default: avgVal = SUM_W'(1) << (PIX_W - 1);
    endcase
    dcVal = avgVal[PIX_W-1:0];
  end

endmodule

// File: rtl/intra_pred_dp.sv
module intra_pred_dp
  import intra_pred_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strobes,
  input  logic [1:0]               reqMode,
  input  logic [1:0]               reqSize,
  input  logic                     aboveAvail,
  input  logic                     leftAvail,
  input  logic [MAX_DIM*PIX_W-1:0] abovePix,
  input  logic [MAX_DIM*PIX_W-1:0] leftPix,
  input  logic [PIX_W-1:0]         cornerPix,
  output logic [MAX_DIM*PIX_W-1:0] rowData
);

  localparam int GRAD_W  = PIX_W + 2;
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  predMode_t                modeQ;
  logic [2:0]               log2Q;
  logic                     availAboveQ;
  logic                     availLeftQ;
  logic [MAX_DIM*PIX_W-1:0] aboveQ;
  logic [MAX_DIM*PIX_W-1:0] leftQ;
  logic [PIX_W-1:0]         cornerQ;
  logic [PIX_W-1:0]         dcVal;
  logic [PIX_W-1:0]         leftSel;
  logic [ROW_W:0]           dimQ;
  logic [PIX_W-1:0]         laneVal [MAX_DIM];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ       <= MODE_HORZ;
      log2Q       <= 3'd2;
      availAboveQ <= 1'b0;
      availLeftQ  <= 1'b0;
      aboveQ      <= '0;
      leftQ       <= '0;
      cornerQ     <= '0;
    end else if (strobes.load) begin
      modeQ       <= predMode_t'(reqMode);
      log2Q       <= sizeToLog2(reqSize);
      availAboveQ <= aboveAvail;
      availLeftQ  <= leftAvail;
      aboveQ      <= abovePix;
      leftQ       <= leftPix;
      cornerQ     <= cornerPix;
    end
  end

  assign dimQ    = (ROW_W+1)'(1) << log2Q;
  assign leftSel = leftQ[strobes.rowIdx*PIX_W +: PIX_W];

  intra_pred_dc #(.PIX_W(PIX_W)) u_dc (
    .aboveFlat (aboveQ),
    .leftFlat  (leftQ),
    .log2Dim   (log2Q),
    .availAbove(availAboveQ),
    .availLeft (availLeftQ),
    .dcVal     (dcVal)
  );

  for (genvar j = 0; j < MAX_DIM; j++) begin : g_lane
    logic [PIX_W-1:0]         abovePx;
    logic signed [GRAD_W-1:0] gradRaw;
    logic [PIX_W-1:0]         gradSat;

    assign abovePx = aboveQ[j*PIX_W +: PIX_W];
    assign gradRaw = $signed({2'b00, leftSel}) + $signed({2'b00, abovePx})
                   - $signed({2'b00, cornerQ});

    always_comb begin
      if (gradRaw < 0)                         gradSat = '0;
      else if (gradRaw > GRAD_W'(PIX_MAX))     gradSat = PIX_W'(PIX_MAX);
      else                                     gradSat = gradRaw[PIX_W-1:0];
    end

    always_comb begin
      if ((ROW_W+1)'(j) >= dimQ) begin
        laneVal[j] = '0;
      end else begin
        case (modeQ)
          MODE_HORZ: laneVal[j] = leftSel;
          MODE_VERT: laneVal[j] = abovePx;
          MODE_DC:   laneVal[j] = dcVal;
          default:   laneVal[j] = gradSat;
        endcase
      end
    end

    assign rowData[j*PIX_W +: PIX_W] = laneVal[j];

    if (j > 0) begin : g_uniform
      assert_uniform_row_R2: assert property (@(posedge clk) disable iff (!rstN)
        (strobes.busy && (modeQ == MODE_HORZ || modeQ == MODE_DC) && (ROW_W+1)'(j) < dimQ)
          |-> (laneVal[j] == laneVal[0]));
    end
  end

  assert_vert_repeat_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.busy && strobes.advance && modeQ == MODE_VERT) |=> $stable(rowData));

  assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.busy && !strobes.advance) |=> $stable(rowData));

  assert_no_reload_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.busy |-> !strobes.load);

endmodule

// File: rtl/intra_pred_top.sv
module intra_pred_top
  import intra_pred_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [1:0]               reqMode,
  input  logic [1:0]               reqSize,
  input  logic                     aboveAvail,
  input  logic                     leftAvail,
  input  logic [MAX_DIM*PIX_W-1:0] abovePix,
  input  logic [MAX_DIM*PIX_W-1:0] leftPix,
  input  logic [PIX_W-1:0]         cornerPix,
  output logic                     rowValid,
  input  logic                     rowReady,
  output logic [MAX_DIM*PIX_W-1:0] rowData,
  output logic [ROW_W-1:0]         rowIndex,
  output logic                     rowLast
);

  ctrlStrobes_t strobes;

  intra_pred_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .reqSize (reqSize),
    .rowValid(rowValid),
    .rowReady(rowReady),
    .rowLast (rowLast),
    .rowIndex(rowIndex),
    .strobes (strobes)
  );

  intra_pred_dp #(.PIX_W(PIX_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqMode   (reqMode),
    .reqSize   (reqSize),
    .aboveAvail(aboveAvail),
    .leftAvail (leftAvail),
    .abovePix  (abovePix),
    .leftPix   (leftPix),
    .cornerPix (cornerPix),
    .rowData   (rowData)
  );

endmodule

// File: tb/intra_pred_top_tb.sv
module intra_pred_top_tb;

  logic         clk = 1'b0;
  logic         rstN;
  logic         reqValid;
  logic         reqReady;
  logic [1:0]   reqMode;
  logic [1:0]   reqSize;
  logic         aboveAvail;
  logic         leftAvail;
  logic [127:0] abovePix;
  logic [127:0] leftPix;
  logic [7:0]   cornerPix;
  logic         rowValid;
  logic         rowReady;
  logic [127:0] rowData;
  logic [3:0]   rowIndex;
  logic         rowLast;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int seed   = 24681;

  logic [7:0] aP [16];
  logic [7:0] lP [16];
  logic [7:0] cP;

  always #10 clk = ~clk;

  intra_pred_top u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqMode(reqMode), .reqSize(reqSize), .aboveAvail(aboveAvail),
    .leftAvail(leftAvail), .abovePix(abovePix), .leftPix(leftPix),
    .cornerPix(cornerPix), .rowValid(rowValid), .rowReady(rowReady),
    .rowData(rowData), .rowIndex(rowIndex), .rowLast(rowLast)
  );

  function int rnd8();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 255;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int expPix(int mode, int r, int j, int dcv);
    int g;
    case (mode)
      0: return lP[r];
      1: return aP[j];
      2: return dcv;
      default: begin
        g = int'(lP[r]) + int'(aP[j]) - int'(cP);
        if (g < 0) g = 0;
        if (g > 255) g = 255;
        return g;
      end
    endcase
  endfunction

  task automatic runBlock(int mode, int size, bit aA, bit aL, int pat, int stallEvery, bit holdReq);
    int n;
    int lg;
    int sA;
    int sL;
    int dcv;
    string tag;
    logic [127:0] expRow;
    logic [127:0] lowMask;
    logic [127:0] held;
    lg = (size >= 2) ? 4 : size + 2;
    n  = 1 << lg;
    for (int k = 0; k < 16; k++) begin
      case (pat)
        1: begin aP[k] = (k % 2) ? 8'd255 : 8'd0; lP[k] = (k % 3 == 0) ? 8'd255 : 8'd0; end
        3: begin aP[k] = 8'd255; lP[k] = 8'd255; end
        default: begin aP[k] = 8'(rnd8()); lP[k] = 8'(rnd8()); end
      endcase
      abovePix[k*8 +: 8] = aP[k];
      leftPix[k*8 +: 8]  = lP[k];
    end
    cP = (pat == 1) ? 8'd128 : 8'(rnd8());
    cornerPix = cP;
    sA = 0; sL = 0;
    for (int k = 0; k < n; k++) begin sA += aP[k]; sL += lP[k]; end
    if (aA && aL)  begin dcv = (sA + sL + n) >> (lg + 1); tag = "R4"; end
    else if (aA)   begin dcv = (sA + n / 2) >> lg; tag = "R5"; end
    else if (aL)   begin dcv = (sL + n / 2) >> lg; tag = "R5"; end
    else           begin dcv = 128; tag = "R6"; end
    if (mode == 0) tag = "R2/R12";
    if (mode == 1) tag = "R3/R12";
    if (mode == 3) tag = "R7/R12";
    reqMode = 2'(mode); reqSize = 2'(size);
    aboveAvail = aA; leftAvail = aL;
    reqValid = 1'b1; rowReady = 1'b0;
    check(reqReady == 1'b1, "R10 idle before request", 128'(reqReady), 128'd1);
    @(posedge clk); @(negedge clk);
    reqValid = holdReq;
    abovePix = ~abovePix; leftPix = {leftPix[63:0], leftPix[127:64]};
    cornerPix = cornerPix + 8'd77; aboveAvail = ~aA; leftAvail = ~aL;
    reqMode = 2'(mode + 1); reqSize = 2'(size + 1);
    lowMask = (n == 16) ? '1 : ((128'd1 << (8 * n)) - 1);
    for (int r = 0; r < n; r++) begin
      expRow = '0;
      for (int j = 0; j < n; j++) expRow[j*8 +: 8] = 8'(expPix(mode, r, j, dcv));
      check(rowValid && rowIndex == 4'(r) && rowLast == (r == n - 1),
            "R1 beat index/last", {rowValid, rowLast, 4'(rowIndex)}, {1'b1, (r == n - 1), 4'(r)});
      check((rowData & lowMask) == expRow, {tag, "/R11 row value"}, rowData & lowMask, expRow);
      if (n < 16)
        check((rowData & ~lowMask) == '0, "R8 unused lanes", rowData & ~lowMask, '0);
      if (stallEvery > 0 && (r % stallEvery) == 0) begin
        held = rowData;
        @(posedge clk); @(negedge clk);
        check(rowValid && rowData == held && rowIndex == 4'(r), "R9 stall hold", rowData, held);
      end
      rowReady = 1'b1;
      @(posedge clk); @(negedge clk);
      rowReady = 1'b0;
    end
    check(!rowValid && reqReady, "R10 reopen after last", {rowValid, reqReady}, 128'b01);
    reqValid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; rowReady = 1'b0; reqMode = '0; reqSize = '0;
    aboveAvail = 1'b0; leftAvail = 1'b0; abovePix = '0; leftPix = '0; cornerPix = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!rowValid && reqReady, "R10 reset state", {rowValid, reqReady}, 128'b01);
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 3; s++)
        for (int av = 0; av < 4; av++)
          runBlock(m, s, av[1], av[0], 0, (av == 2) ? 3 : 0, av == 1);
    for (int s = 0; s < 3; s++) runBlock(3, s, 1'b0, 1'b1, 1, 2, 1'b0);
    for (int s = 0; s < 3; s++) runBlock(2, s, 1'b1, 1'b1, 3, 0, 1'b1);
    runBlock(0, 3, 1'b1, 1'b0, 0, 5, 1'b0);
    runBlock(1, 3, 1'b0, 1'b0, 0, 1, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule